// File: doc/BRIEF.md
# SMBus Byte-Access Memory Target

This block is an SMBus target that exposes 256 bytes of memory to a bus host through single-byte transactions. The memory is split by the top bit of the byte address. Locations 0x00 to 0x7F form a read-only information area whose contents are fixed constants: each byte holds the bitwise inverse of its own index. Locations 0x80 to 0xFF form a scratch area that the host may write and read back.

The target oversamples the open-drain SCL and SDA lines with a system clock. It finds start and stop conditions, shifts in its 7-bit device address, and answers only when that address matches its own. The address is built from a fixed 4-bit device code, a constant 0 bit, and two strap inputs. After a match, the first byte the host sends is the memory address. A Write Byte transaction then carries one data byte. A Read Byte transaction uses a repeated start and then the address with the read bit, after which the target returns one byte.

A write that falls in the read-only area is acknowledged in the normal way, but the target drops its data. The target only ever pulls SDA low; it never drives SCL.

Top module: `smb_byte_target`

## Requirements
- R1: While reset is high, and in the first cycle after it, SDA is released (`sda_oe` = 0).
- R2: The target acknowledges an address byte only when its upper 7 bits equal {DEV_ID (default 4'b1010), 1'b0, addr_strap[1:0]}. On any other address it acknowledges nothing and keeps SDA released until the next start.
- R3: A Write Byte transaction (start, address with R/W = 0, memory address byte, data byte, stop) gets an ACK after each of its three bytes. When the memory address has bit 7 = 1, the data byte is stored at that location.
- R4: A Write Byte transaction whose memory address has bit 7 = 0 is acknowledged on all three bytes, and the addressed byte keeps its previous value.
- R5: A Read Byte transaction works as follows. The host sends start, the address with R/W = 0 and the memory address byte, then a repeated start and the address with R/W = 1. After acknowledging that address, the target drives the addressed byte most significant bit first, then releases SDA for the host's NACK.
- R6: A read of read-only location i returns ~i (for example, 0x00 reads as 0xFF and 0x7F reads as 0x80).
- R7: The target changes its SDA drive only while SCL is low.
- R8: A start condition in the middle of a transfer discards the partial byte and restarts address reception, so a complete transaction that follows it is served correctly.
- R9: A stop condition returns the target to idle with SDA released, from any point in a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| addr_strap | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The read-only area is read at its first location, at its last location and at an arbitrary location in between. Comparing each result with the inverted index confirms the address decode and the MSB-first bit order. Writes to the scratch area use two different addresses with different data, then both are read back, so a stored value cannot be mistaken for a default value or a shared location. A write into the read-only area followed by a read of the same location separates "acknowledged and dropped" from "acknowledged and stored". The remaining tests cover addresses that differ in the device code, in the fixed zero bit and in the strap bits, plus a start and a stop issued in the middle of a byte. These show that nothing responds to a wrong address and that a broken transfer leaves no state behind.

// File: rtl/smb_mem_pkg.sv
package smb_mem_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } bus_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_now, sda_now;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_now <= 1'b1;
          sda_now <= 1'b1;
        end else begin
          scl_now <= scl_i;
          sda_now <= sda_i;
        end
      end
    end else begin : g_chain
      logic [STAGES-1:0] scl_pipe, sda_pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
      assign scl_now = scl_pipe[STAGES-1];
      assign sda_now = sda_pipe[STAGES-1];
    end
  endgenerate

  // one more register gives the previous level for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_now;
      sda_d <= sda_now;
    end
  end

  assign sda_s     = sda_now;
  assign scl_rise  =  scl_now & ~scl_d;
  assign scl_fall  = ~scl_now &  scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det =  scl_now & scl_d &  sda_d & ~sda_now;
  assign stop_det  =  scl_now & scl_d & ~sda_d &  sda_now;

endmodule

// File: rtl/smb_byte_mem.sv
module smb_byte_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  localparam int HALF = 2 ** (AW - 1);

  // constant contents of the protected half: inverted index
  function automatic logic [DW-1:0] info_byte(input logic [AW-1:0] idx);
    return ~DW'(idx);
  endfunction

  logic [DW-1:0] ram [HALF];
  logic [DW-1:0] ram_q, rom_q;
  logic          hi_q;

  // only the writable half is a real memory; upper-half writes only
  always_ff @(posedge clk) begin
    if (wr_en && wr_addr[AW-1])
      ram[wr_addr[AW-2:0]] <= wr_data;
    ram_q <= ram[rd_addr[AW-2:0]];
  end

  always_ff @(posedge clk) begin
    rom_q <= info_byte(rd_addr);
    hi_q  <= rd_addr[AW-1];
  end

  assign rd_data = hi_q ? ram_q : rom_q;

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_mem_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] mem_q,
  output logic [BYTE_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_oe,
  output bus_state_t        state_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sh;
  logic              is_read;
  logic              ack_on;
  logic [BYTE_W-1:0] rx_byte;
  logic [6:0]        my_addr;
  logic              byte_done;

  assign rx_byte   = {sh, sda_s};
  assign my_addr   = {DEV_ID, 1'b0, strap};
  assign byte_done = scl_rise && (cnt == LAST_BIT);
  assign state_o   = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      is_read   <= 1'b0;
      ack_on    <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;

          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= rx_byte[BYTE_W-2:0];
              cnt <= cnt + 1'b1;
            end
            if (byte_done) begin
              cnt <= '0;
              if (rx_byte[7:1] == my_addr) begin
                is_read <= rx_byte[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end

          ST_CMD: begin
            if (scl_rise) begin
              sh  <= rx_byte[BYTE_W-2:0];
              cnt <= cnt + 1'b1;
            end
            if (byte_done) begin
              cnt      <= '0;
              mem_addr <= rx_byte;
              state    <= ST_CMD_ACK;
            end
          end

          ST_WDATA: begin
            if (scl_rise) begin
              sh  <= rx_byte[BYTE_W-2:0];
              cnt <= cnt + 1'b1;
            end
            if (byte_done) begin
              cnt       <= '0;
              mem_we    <= 1'b1;
              mem_wdata <= rx_byte;
              state     <= ST_WDATA_ACK;
            end
          end

          ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                ack_on <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
                cnt    <= '0;
                if (state == ST_ADDR_ACK) begin
                  if (is_read) begin
                    state  <= ST_RDATA;
                    sh     <= mem_q[BYTE_W-2:0];
                    sda_oe <= ~mem_q[BYTE_W-1];
                  end else begin
                    state <= ST_CMD;
                  end
                end else if (state == ST_CMD_ACK) begin
                  state <= ST_WDATA;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end

          ST_RDATA: begin
            if (scl_rise)
              cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_oe <= 1'b0;
                state  <= ST_RDATA_ACK;
              end else begin
                sh     <= {sh[BYTE_W-3:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end

          ST_RDATA_ACK: begin
            if (scl_rise)
              state <= ST_IDLE;
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_byte_target.sv
module smb_byte_target
  import smb_mem_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap,
  output logic       sda_oe
);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] mem_q, mem_addr, mem_wdata;
  logic              mem_we;
  bus_state_t        bus_state;

  smb_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smb_proto_fsm #(
    .DEV_ID(DEV_ID)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (addr_strap),
    .mem_q    (mem_q),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .sda_oe   (sda_oe),
    .state_o  (bus_state)
  );

  smb_byte_mem #(
    .AW(BYTE_W),
    .DW(BYTE_W)
  ) u_mem (
    .clk    (clk),
    .rd_addr(mem_addr),
    .rd_data(mem_q),
    .wr_en  (mem_we),
    .wr_addr(mem_addr),
    .wr_data(mem_wdata)
  );

endmodule

// File: rtl/smb_byte_target_chk.sv
module smb_byte_target_chk
  import smb_mem_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input bus_state_t state,
  input logic       mem_we
);

  AST_RESET_RELEASED: assert property (@(posedge clk) rst |=> (!sda_oe && state == ST_IDLE)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE) |-> !sda_oe); // R9

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_i); // R7

  AST_DRIVE_IN_OWN_SLOTS: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK ||
                state == ST_WDATA_ACK || state == ST_RDATA)); // R5

  AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R3

endmodule

bind smb_byte_target smb_byte_target_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .scl_i (scl_i),
  .sda_oe(sda_oe),
  .state (bus_state),
  .mem_we(mem_we)
);

// File: tb/sim_smb_byte_target.sv
module sim_smb_byte_target;

  localparam int CLK_P   = 10;
  localparam int Q       = 6;
  localparam int WD_MAX  = 150000;
  localparam logic [6:0] BASE = 7'b1010_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_oe;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int oe_seen = 0;
  int r7_bad = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  assign sda_line = host_sda & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  smb_byte_target u0 (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (host_scl),
    .sda_i     (sda_line),
    .addr_strap(strap),
    .sda_oe    (sda_oe)
  );

  // bus monitor: drive activity and SDA changes while SCL is high
  always @(negedge clk) begin
    if (sda_oe) oe_seen++;
    if (!rst && (sda_oe !== oe_prev) && host_scl) r7_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b0; qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    host_sda = b;    qw();
    host_scl = 1'b1; qw(); qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    b = sda_line;    qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
  endtask

  // nk: bit per byte, 1 means not acknowledged
  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                          output logic [2:0] nk);
    bus_start();
    send_byte({a, 1'b0}); recv_bit(nk[2]);
    send_byte(c);         recv_bit(nk[1]);
    send_byte(d);         recv_bit(nk[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c,
                         output logic [2:0] nk, output logic [7:0] d);
    bus_start();
    send_byte({a, 1'b0}); recv_bit(nk[2]);
    send_byte(c);         recv_bit(nk[1]);
    bus_start();
    send_byte({a, 1'b1}); recv_bit(nk[0]);
    recv_byte(d);
    send_bit(1'b1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 reset release", int'(sda_oe), 0);
  endtask

  task automatic t_info_read();
    logic [2:0] nk; logic [7:0] d;
    logic [7:0] idx [3] = '{8'h00, 8'h5C, 8'h7F};
    foreach (idx[k]) begin
      do_read(BASE, idx[k], nk, d);
      chk(nk == 3'b000, "R5 read acks", int'(nk), 0);
      chk(d == ~idx[k], "R6 info byte", int'(d), int'(~idx[k]));
    end
  endtask

  task automatic t_scratch();
    logic [2:0] nk; logic [7:0] d;
    do_write(BASE, 8'h80, 8'hA5, nk);
    chk(nk == 3'b000, "R3 write acks", int'(nk), 0);
    do_write(BASE, 8'hFF, 8'h3C, nk);
    chk(nk == 3'b000, "R3 write acks", int'(nk), 0);
    do_read(BASE, 8'h80, nk, d);
    chk(d == 8'hA5, "R3 readback 80", int'(d), 'hA5);
    do_read(BASE, 8'hFF, nk, d);
    chk(d == 8'h3C, "R3 readback FF", int'(d), 'h3C);
  endtask

  task automatic t_protected();
    logic [2:0] nk; logic [7:0] d;
    do_write(BASE, 8'h10, 8'h00, nk);
    chk(nk == 3'b000, "R4 protected write acks", int'(nk), 0);
    do_read(BASE, 8'h10, nk, d);
    chk(d == 8'hEF, "R4 protected unchanged", int'(d), 'hEF);
  endtask

  task automatic t_mismatch();
    logic [2:0] nk;
    logic [6:0] bad [3] = '{7'b1011_000, 7'b1010_100, 7'b1010_001};
    foreach (bad[k]) begin
      oe_seen = 0;
      do_write(bad[k], 8'h81, 8'h77, nk);
      chk(nk == 3'b111, "R2 wrong address nack", int'(nk), 7);
      chk(oe_seen == 0, "R2 SDA stays released", oe_seen, 0);
    end
  endtask

  task automatic t_strap();
    logic [2:0] nk; logic [7:0] d;
    strap = 2'b11;
    repeat (4) @(negedge clk);
    do_write(BASE | 7'd3, 8'hC4, 8'h69, nk);
    chk(nk == 3'b000, "R2 strap 11 acks", int'(nk), 0);
    do_read(BASE, 8'hC4, nk, d);
    chk(nk == 3'b111, "R2 old strap nack", int'(nk), 7);
    do_read(BASE | 7'd3, 8'hC4, nk, d);
    chk(d == 8'h69, "R2 strap readback", int'(d), 'h69);
    strap = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_restart();
    logic [2:0] nk; logic ak; logic [7:0] d;
    bus_start();
    send_byte({BASE, 1'b0}); recv_bit(ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_write(BASE, 8'h90, 8'h5A, nk);
    chk(nk == 3'b000, "R8 write after restart acks", int'(nk), 0);
    do_read(BASE, 8'h90, nk, d);
    chk(d == 8'h5A, "R8 data after restart", int'(d), 'h5A);
  endtask

  task automatic t_stop_mid();
    logic [2:0] nk; logic [7:0] d;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);
    do_read(BASE, 8'h22, nk, d);
    chk(nk == 3'b000, "R9 next read acks", int'(nk), 0);
    chk(d == 8'hDD, "R9 next read data", int'(d), 'hDD);
  endtask

  initial begin : watchdog
    repeat (WD_MAX) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", WD_MAX, WD_MAX);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_info_read();
    t_scratch();
    t_protected();
    t_mismatch();
    t_strap();
    t_restart();
    t_stop_mid();
    chk(r7_bad == 0, "R7 SDA change with SCL high", r7_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule